// File: doc/BRIEF.md
# Video pixel input formatter

The formatter sits at the front of a video output path. Every pixel clock it accepts one word from a 24-bit parallel pixel bus and turns it into a single normalized 24-bit pixel, with tags that the stages behind it use. Four bus packings are accepted: full 4:4:4 at 24 bits, 4:2:2 luma with chroma that alternates between samples, 15-bit 5-5-5 direct colour, and an 8-bit index into a writable 256-entry palette. A format field says whether the resulting word is RGB, GBR (which is rotated into R,G,B order) or already luma/chroma. The formatter does not convert colour spaces itself.

Configuration comes from one control byte that is written on a strobe. The byte is held as a pending value and becomes active only on a line-start pulse, so a line is never split between two configurations. The active byte also yields a test-pattern request code (colour bars or a modulated ramp). While a request is active, the pixel data is forced to zero, which lets a downstream generator take over the output. A sticky-free error output shows when the pending byte holds a field combination that is forbidden while layering is enabled.

Top module: `pixel_formatter`

## Requirements
- R1: With mode field ctrl[1:0]=00, the pixel on pix_data_i[23:0] leaves on pix_data_o one clock later. pix_valid_o is pix_valid_i delayed by one clock. This latency is the same in every mode.
- R2: Format field ctrl[3:2] decides how the word is ordered. 00 (RGB) and the reserved code 01 pass the word through. 10 (GBR) reads bus bytes [23:16],[15:8],[7:0] as G,B,R and outputs them as R,G,B. 11 passes the word through and sets is_yc_o. With the 24-bit, 15-bit and palette packings, is_yc_o is 1 exactly when the field is 11.
- R3: With mode 10, bits [14:10],[9:5],[4:0] are three 5-bit channels. Each channel c becomes the byte {c, c[4:2]}, and the bytes sit at [23:16],[15:8],[7:0]. The result is then ordered as in R2.
- R4: With mode 01, the output is Y=bus[23:16] in [23:16]. The chroma byte bus[15:8] goes to [15:8] on a Cb pixel or to [7:0] on a Cr pixel, and the other byte is zero. chroma_cr_o flags Cr. The phase toggles on each accepted pixel and returns to Cb after a line-start pulse. is_yc_o is 1 and the format field is not applied.
- R5: With mode 11, bus[7:0] indexes the palette and the output is the stored 24-bit entry, ordered as in R2. Palette writes go through pal_we_i/pal_addr_i/pal_data_i. A read and a write to the same entry in one cycle return the old entry.
- R6: When the ramp bit ctrl[5] and the bar bit ctrl[4] are both 1, test_req_o=10 (ramp) and pix_data_o is zero.
- R7: When ctrl[4], ctrl[5] and ctrl[0] are all 0, test_req_o=01 (bars) and pix_data_o is zero. Every other combination gives test_req_o=00.
- R8: A control write is held as pending and has no effect on the data path until a line-start pulse. A pixel accepted in the same cycle as the pulse still uses the old configuration. Pixels accepted after the pulse use the new one.
- R9: One cycle after a control write, cfg_err_o is 1 if the written byte has layer bit ctrl[6]=1 together with format 01 or mode 10, and 0 otherwise. The layer bit has no other effect.
- R10: Control bit 7 has no effect on any output.
- R11: After reset, the outputs are zero and the active and pending control byte is 0x10 (24-bit RGB, no test request).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | pixel clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| ctrl_we_i | input | 1 | control byte write strobe |
| ctrl_data_i | input | 8 | control byte |
| line_start_i | input | 1 | line-start pulse, applies pending control |
| pix_valid_i | input | 1 | input pixel valid |
| pix_data_i | input | 24 | parallel pixel bus |
| pal_we_i | input | 1 | palette write enable |
| pal_addr_i | input | 8 | palette write address |
| pal_data_i | input | 24 | palette write data |
| pix_valid_o | output | 1 | output pixel valid |
| pix_data_o | output | 24 | normalized pixel |
| is_yc_o | output | 1 | pixel is already luma/chroma |
| chroma_cr_o | output | 1 | 4:2:2 chroma of this pixel is Cr |
| test_req_o | output | 2 | 00 none, 01 colour bars, 10 ramp |
| cfg_err_o | output | 1 | pending control byte is a forbidden combination |

## Verification
The bench uses the default build: 8-bit channels and a 256-entry palette with an 8-bit address. With these sizes, every one of the 256 control bytes can be applied, each with its own pixel patterns. The bench also drives all 32768 15-bit codes and reads every palette index, in GBR order and in luma/chroma order. Each response is compared with a value worked out arithmetically from the requirements.

// File: rtl/pxfmt_pkg.sv
package pxfmt_pkg;
  localparam int CH_W  = 8;
  localparam int PIX_W = 3 * CH_W;

  localparam logic [1:0] MODE_444 = 2'b00;
  localparam logic [1:0] MODE_422 = 2'b01;
  localparam logic [1:0] MODE_555 = 2'b10;
  localparam logic [1:0] MODE_IDX = 2'b11;

  localparam logic [1:0] FMT_RGB = 2'b00;
  localparam logic [1:0] FMT_RSV = 2'b01;
  localparam logic [1:0] FMT_GBR = 2'b10;
  localparam logic [1:0] FMT_YC  = 2'b11;

  localparam logic [1:0] TST_NONE = 2'b00;
  localparam logic [1:0] TST_BARS = 2'b01;
  localparam logic [1:0] TST_RAMP = 2'b10;

  typedef struct packed {
    logic       rsvd;
    logic       layer_en;
    logic       ramp_en;
    logic       bar_n;
    logic [1:0] fmt;
    logic [1:0] mode;
  } cfg_t;

  localparam logic [7:0] CFG_RST = 8'h10;
endpackage

// File: rtl/pxfmt_cfg.sv
module pxfmt_cfg
  import pxfmt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] data_i,
  input  logic       line_start_i,
  output cfg_t       act_o,
  output logic [1:0] test_o,
  output logic       err_o
);
  cfg_t       pend_q, act_q;
  logic [1:0] test_d, test_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= cfg_t'(CFG_RST);
      act_q  <= cfg_t'(CFG_RST);
      test_q <= TST_NONE;
    end else begin
      if (we_i)         pend_q <= cfg_t'(data_i);
      if (line_start_i) act_q  <= pend_q;
      test_q <= test_d;
    end
  end

  always_comb begin
    if (act_q.ramp_en && act_q.bar_n)                        test_d = TST_RAMP;
    else if (!act_q.bar_n && !act_q.ramp_en && !act_q.mode[0]) test_d = TST_BARS;
    else                                                     test_d = TST_NONE;
  end

  assign err_o  = pend_q.layer_en && (pend_q.fmt == FMT_RSV || pend_q.mode == MODE_555);
  assign act_o  = act_q;
  assign test_o = test_q;

  a_r8_act_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_start_i |=> $stable(act_q));
  a_r9_err_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(err_o));
  a_r7_one_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(test_q));
endmodule

// File: rtl/pxfmt_palette.sv
module pxfmt_palette #(
  parameter int AW = 8,
  parameter int DW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  // read-before-write on address collision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= mem[raddr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/pxfmt_unpack.sv
module pxfmt_unpack
  import pxfmt_pkg::*;
(
  input  logic [1:0]       mode_i,
  input  logic [1:0]       fmt_i,
  input  logic             cr_i,
  input  logic [PIX_W-1:0] raw_i,
  input  logic [PIX_W-1:0] pal_i,
  output logic [PIX_W-1:0] pix_o
);
  localparam int SW = 5;
  localparam int RW = CH_W - SW;

  logic [PIX_W-1:0] wide, word, ordered;

  for (genvar g = 0; g < 3; g++) begin : g_expand
    assign wide[g*CH_W +: CH_W] = {raw_i[g*SW +: SW], raw_i[g*SW + SW - RW +: RW]};
  end

  always_comb begin
    case (mode_i)
      MODE_555: word = wide;
      MODE_IDX: word = pal_i;
      default:  word = raw_i;
    endcase
    if (fmt_i == FMT_GBR)
      ordered = {word[CH_W-1:0], word[PIX_W-1 -: CH_W], word[CH_W +: CH_W]};
    else
      ordered = word;
    if (mode_i == MODE_422)
      pix_o = cr_i ? {raw_i[PIX_W-1 -: CH_W], {CH_W{1'b0}}, raw_i[CH_W +: CH_W]}
                   : {raw_i[PIX_W-1 -: CH_W], raw_i[CH_W +: CH_W], {CH_W{1'b0}}};
    else
      pix_o = ordered;
  end
endmodule

// File: rtl/pixel_formatter.sv
module pixel_formatter
  import pxfmt_pkg::*;
#(
  parameter int PAL_AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [7:0]        ctrl_data_i,
  input  logic              line_start_i,
  input  logic              pix_valid_i,
  input  logic [23:0]       pix_data_i,
  input  logic              pal_we_i,
  input  logic [PAL_AW-1:0] pal_addr_i,
  input  logic [23:0]       pal_data_i,
  output logic              pix_valid_o,
  output logic [23:0]       pix_data_o,
  output logic              is_yc_o,
  output logic              chroma_cr_o,
  output logic [1:0]        test_req_o,
  output logic              cfg_err_o
);
  cfg_t             act;
  logic [1:0]       test;
  logic             phase_q;
  logic             valid_q, cr_q, yc_q;
  logic [1:0]       mode_q, fmt_q;
  logic [PIX_W-1:0] raw_q, pal_rd, fmt_pix;
  logic             is_422;

  pxfmt_cfg u_cfg (
    .clk_i, .rst_ni,
    .we_i         (ctrl_we_i),
    .data_i       (ctrl_data_i),
    .line_start_i (line_start_i),
    .act_o        (act),
    .test_o       (test),
    .err_o        (cfg_err_o)
  );

  pxfmt_palette #(.AW(PAL_AW), .DW(PIX_W)) u_pal (
    .clk_i, .rst_ni,
    .we_i    (pal_we_i),
    .waddr_i (pal_addr_i),
    .wdata_i (pal_data_i),
    .re_i    (pix_valid_i && act.mode == MODE_IDX),
    .raddr_i (pix_data_i[PAL_AW-1:0]),
    .rdata_o (pal_rd)
  );

  assign is_422 = (act.mode == MODE_422);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      valid_q <= 1'b0;
      raw_q   <= '0;
      mode_q  <= MODE_444;
      fmt_q   <= FMT_RGB;
      cr_q    <= 1'b0;
      yc_q    <= 1'b0;
    end else begin
      valid_q <= pix_valid_i;
      if (line_start_i)               phase_q <= 1'b0;
      else if (pix_valid_i && is_422) phase_q <= ~phase_q;
      if (pix_valid_i) begin
        raw_q  <= pix_data_i;
        mode_q <= act.mode;
        fmt_q  <= act.fmt;
        cr_q   <= phase_q && is_422;
        yc_q   <= is_422 || act.fmt == FMT_YC;
      end
    end
  end

  pxfmt_unpack u_unpack (
    .mode_i (mode_q),
    .fmt_i  (fmt_q),
    .cr_i   (cr_q),
    .raw_i  (raw_q),
    .pal_i  (pal_rd),
    .pix_o  (fmt_pix)
  );

  assign pix_valid_o = valid_q;
  assign pix_data_o  = (test != TST_NONE) ? '0 : fmt_pix;
  assign is_yc_o     = yc_q;
  assign chroma_cr_o = cr_q;
  assign test_req_o  = test;

  a_r1_valid_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_i |=> pix_valid_o);
  a_r4_phase_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start_i |=> !phase_q);
  a_r6_override_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_o && test_req_o != TST_NONE) |-> pix_data_o == '0);
  a_r4_cr_only_422: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chroma_cr_o |-> is_yc_o);
endmodule

// File: tb/sim_pixel_formatter.sv
`timescale 1ns/1ps
module sim_pixel_formatter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_we = 1'b0;
  logic [7:0]  ctrl_data = '0;
  logic        line_start = 1'b0;
  logic        pix_valid = 1'b0;
  logic [23:0] pix_data = '0;
  logic        pal_we = 1'b0;
  logic [7:0]  pal_addr = '0;
  logic [23:0] pal_data = '0;
  logic        valid_o, yc_o, cr_o, err_o;
  logic [23:0] data_o;
  logic [1:0]  test_o;

  int n_vec = 0;
  int n_bad = 0;
  logic [7:0]  pend_m = 8'h10;
  logic [7:0]  act_m  = 8'h10;
  logic        phase_m = 1'b0;
  logic [23:0] pal_m [256];

  always #4 clk = ~clk;

  pixel_formatter u0 (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_we_i(ctrl_we), .ctrl_data_i(ctrl_data),
    .line_start_i(line_start), .pix_valid_i(pix_valid), .pix_data_i(pix_data),
    .pal_we_i(pal_we), .pal_addr_i(pal_addr), .pal_data_i(pal_data),
    .pix_valid_o(valid_o), .pix_data_o(data_o), .is_yc_o(yc_o),
    .chroma_cr_o(cr_o), .test_req_o(test_o), .cfg_err_o(err_o)
  );

  function automatic logic [23:0] pal_val(int i);
    logic [7:0] b = 8'(i);
    return {b ^ 8'hA5, ~b, 8'(b * 3 + 1)};
  endfunction

  function automatic logic [1:0] exp_code(logic [7:0] c);
    if (c[5] && c[4]) return 2'b10;
    if (!c[4] && !c[5] && !c[0]) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [23:0] exp_data(logic [7:0] c, logic [23:0] d, logic ph);
    logic [23:0] w;
    if (exp_code(c) != 2'b00) return 24'h0;
    case (c[1:0])
      2'b01: return ph ? {d[23:16], 8'h00, d[15:8]} : {d[23:16], d[15:8], 8'h00};
      2'b10: w = {d[14:10], d[14:12], d[9:5], d[9:7], d[4:0], d[4:2]};
      2'b11: w = pal_m[d[7:0]];
      default: w = d;
    endcase
    if (c[3:2] == 2'b10) w = {w[7:0], w[23:16], w[15:8]};
    return w;
  endfunction

  function automatic string tag_of(logic [7:0] c);
    string t;
    if (exp_code(c) == 2'b10) t = "R6";
    else if (exp_code(c) == 2'b01) t = "R7";
    else case (c[1:0])
      2'b00: t = (c[3:2] == 2'b00) ? "R1" : "R2";
      2'b01: t = "R4";
      2'b10: t = "R3";
      default: t = "R5";
    endcase
    if (c[7]) t = {t, " R10"};
    return t;
  endfunction

  task automatic check(string tag, string what, logic [31:0] got, logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic write_ctrl(logic [7:0] c);
    @(negedge clk); ctrl_we = 1'b1; ctrl_data = c;
    @(negedge clk); ctrl_we = 1'b0;
    pend_m = c;
    check("R9", "cfg_err", 32'(err_o), 32'(c[6] && (c[3:2] == 2'b01 || c[1:0] == 2'b10)));
  endtask

  task automatic pulse_line();
    @(negedge clk); line_start = 1'b1;
    @(negedge clk); line_start = 1'b0;
    act_m = pend_m; phase_m = 1'b0;
  endtask

  // drives one pixel, optionally with a coincident line-start, then checks it
  task automatic px(logic [23:0] d, logic ls, string tag_in);
    string t;
    logic  cr_e;
    t = (tag_in == "") ? tag_of(act_m) : tag_in;
    @(negedge clk); pix_valid = 1'b1; pix_data = d; line_start = ls;
    @(negedge clk); pix_valid = 1'b0; line_start = 1'b0;
    cr_e = phase_m && act_m[1:0] == 2'b01;
    check(t, "valid", 32'(valid_o), 32'd1);
    check(t, "data", 32'(data_o), 32'(exp_data(act_m, d, phase_m)));
    check(t, "is_yc", 32'(yc_o), 32'(act_m[1:0] == 2'b01 || act_m[3:2] == 2'b11));
    check(t, "chroma_cr", 32'(cr_o), 32'(cr_e));
    check(t, "test_req", 32'(test_o), 32'(exp_code(act_m)));
    if (ls) begin act_m = pend_m; phase_m = 1'b0; end
    else if (act_m[1:0] == 2'b01) phase_m = ~phase_m;
  endtask

  initial begin
    #(8 * 190000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11", "valid", 32'(valid_o), 0);
    check("R11", "data", 32'(data_o), 0);
    check("R11", "test_req", 32'(test_o), 0);
    check("R11", "cfg_err", 32'(err_o), 0);
    check("R11", "is_yc", 32'(yc_o), 0);
    px(24'h123456, 1'b0, "R11");

    for (int i = 0; i < 256; i++) begin
      @(negedge clk); pal_we = 1'b1; pal_addr = 8'(i); pal_data = pal_val(i);
      pal_m[i] = pal_val(i);
    end
    @(negedge clk); pal_we = 1'b0;

    // every control byte, several pixel patterns each
    for (int c = 0; c < 256; c++) begin
      write_ctrl(8'(c));
      pulse_line();
      for (int k = 0; k < 6; k++)
        px({8'(c), 8'(c * 7 + k * 29), 8'(k * 37 + 1)}, 1'b0, "");
    end

    // R8 pending versus active
    write_ctrl(8'h10);
    pulse_line();
    px(24'hA1B2C3, 1'b0, "R8");
    write_ctrl(8'h1E);
    px(24'h0F7C21, 1'b0, "R8");
    px(24'h0F7C21, 1'b1, "R8");
    px(24'h0F7C21, 1'b0, "R8");

    // R4 phase restart mid-line
    write_ctrl(8'h11);
    pulse_line();
    px(24'h80C011, 1'b0, "R4");
    px(24'h81C122, 1'b0, "R4");
    px(24'h82C233, 1'b0, "R4");
    pulse_line();
    px(24'h83C344, 1'b0, "R4");

    // R3 all 15-bit codes
    write_ctrl(8'h12);
    pulse_line();
    for (int v = 0; v < 32768; v++) px({9'h0AA, 15'(v)}, 1'b0, "R3");

    // R5 every palette index, GBR and luma/chroma order
    write_ctrl(8'h1B);
    pulse_line();
    for (int i = 0; i < 256; i++) px({16'h5A5A, 8'(i)}, 1'b0, "R5");
    write_ctrl(8'h1F);
    pulse_line();
    for (int i = 0; i < 256; i++) px({16'hC3C3, 8'(255 - i)}, 1'b0, "R5");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule